// File: doc/BRIEF.md
# PWM Time-Base Counter

This block produces the time base that a two-channel pulse-width modulator builds on. The input clock is slowed by two prescalers in series, a power-of-two stage followed by an even-step stage. Each prescaled tick moves a 16-bit counter against a period value, in one of four directions: up, down, up-down or held. The current count is visible at all times. Two one-cycle strobes mark the counter arriving at zero and arriving at the period value. Downstream compare and action logic uses these strobes.

Software-side logic configures the block through a single 16-bit write port that has two targets, a control word and a period word. A period write takes effect at once or waits in a shadow copy, and the control word selects which. A waiting value moves into the active period when the counter next reaches zero, so a cycle already in progress is never cut short by a new period.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, both event strobes are low, the counter is held (mode 3), both prescalers divide by 1, the load mode is shadowed, and the active and shadow periods are 0.
- R2: A write with `wr_sel`=0 loads the control word. Bits 1:0 give the mode (0 up, 1 down, 2 up-down, 3 hold). Bit 3 gives the period load mode (0 shadowed, 1 immediate). Bits 12:10 give k, and bits 9:7 give h. A write with `wr_sel`=1 loads the period word.
- R3: In up mode, each tick raises the count by one. A tick that finds the count equal to or above the period sets the count to 0.
- R4: In down mode, each tick lowers the count by one. A tick that finds the count at 0 reloads the period value.
- R5: In up-down mode the count climbs to the period and then falls to 0, turning around at each end. It steps away from the end it reached, so each end value is held for one tick only. The direction after reset is upward.
- R6: In hold mode the count does not change, no event strobe fires, and the shadow period is not transferred.
- R7: A tick occurs once every 2^k · (h=0 ? 1 : 2h) input clocks. Every control write restarts the prescaler, so that the first tick under the new setting comes that many clocks after the write edge.
- R8: In shadowed mode, a period write changes only the shadow copy. The shadow is copied into the active period on the tick that takes the count to 0.
- R9: In immediate mode, a period write sets the active period and the shadow copy at the same clock edge.
- R10: `zero_evt_o` is high for exactly the cycles that follow a tick which produced a count of 0. `prd_evt_o` is high for exactly the cycles that follow a tick which produced a count equal to the active period in force before that edge.
- R11: With a period of 0, every tick in a running mode leaves the count at 0 and fires both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one register |
| wr_sel | input | 1 | Write target: 0 control word, 1 period word |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current count value |
| zero_evt_o | output | 1 | One-cycle strobe: counter reached zero |
| prd_evt_o | output | 1 | One-cycle strobe: counter reached the period |

## Verification
The bench builds the block with its default widths: a 16-bit counter and two 3-bit prescaler fields. As a result, the largest divide of 1792 clocks and a full-range period register are both reachable. Short periods of 0 to 9 let every mode wrap and turn many times in a short run. The extreme prescaler setting is exercised for a few ticks, which shows that both stages multiply rather than add. Shadowed writes placed in the middle of a cycle and immediate writes that shrink the period below the current count cover the load corner cases.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_HOLD = 2'd3
  } cnt_mode_e;

  localparam int MODE_LSB = 0;
  localparam int IMM_BIT  = 3;
  localparam int HDIV_LSB = 7;
  localparam int KDIV_LSB = 10;
endpackage

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale #(
  parameter int A_W = 3,
  parameter int B_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic [A_W-1:0] k_i,
  input  logic [B_W-1:0] h_i,
  output logic           tick_o
);
  localparam int A_CW = (1 << A_W) - 1;
  localparam int B_CW = B_W + 1;

  logic [A_CW-1:0] a_cnt_q, a_cnt_d, amax;
  logic [B_CW-1:0] b_cnt_q, b_cnt_d, bmax;
  logic            a_wrap;

  always_comb begin
    amax    = ~({A_CW{1'b1}} << k_i);
    bmax    = (h_i == '0) ? '0 : ({h_i, 1'b0} - {{(B_CW-1){1'b0}}, 1'b1});
    a_wrap  = (a_cnt_q == amax);
    tick_o  = a_wrap && (b_cnt_q == bmax);
    a_cnt_d = a_wrap ? '0 : a_cnt_q + {{(A_CW-1){1'b0}}, 1'b1};
    b_cnt_d = b_cnt_q;
    if (a_wrap) b_cnt_d = (b_cnt_q == bmax) ? '0 : b_cnt_q + {{(B_CW-1){1'b0}}, 1'b1};
    if (clr_i) begin
      a_cnt_d = '0;
      b_cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt_q <= '0;
      b_cnt_q <= '0;
    end else begin
      a_cnt_q <= a_cnt_d;
      b_cnt_q <= b_cnt_d;
    end
  end

  // R7
  a_range_chk: assert property (@(posedge clk) disable iff (!rst_n) a_cnt_q <= amax);
  // R7
  b_range_chk: assert property (@(posedge clk) disable iff (!rst_n) b_cnt_q <= bmax);
endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          imm_i,
  input  logic [CW-1:0] data_i,
  input  logic          load_i,
  output logic [CW-1:0] active_o
);
  logic [CW-1:0] act_q, act_d, sh_q, sh_d;

  always_comb begin
    sh_d  = wr_i ? data_i : sh_q;
    act_d = act_q;
    if (load_i) act_d = sh_q;
    if (wr_i && imm_i) act_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      sh_q  <= '0;
    end else begin
      act_q <= act_d;
      sh_q  <= sh_d;
    end
  end

  assign active_o = act_q;

  // R9
  imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && imm_i) |=> (act_q == $past(data_i)));
  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_i && imm_i) && !load_i) |=> $stable(act_q));
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  cnt_mode_e     mode_i,
  input  logic [CW-1:0] prd_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o,
  output logic          prd_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d;
  logic          zero_q, prd_q, adv;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    adv   = tick_i && (mode_i != MODE_HOLD);
    if (adv) begin
      if (prd_i == '0) begin
        cnt_d = '0;
      end else begin
        unique case (mode_i)
          MODE_UP:   cnt_d = (cnt_q >= prd_i) ? '0 : cnt_q + ONE;
          MODE_DOWN: cnt_d = (cnt_q == '0) ? prd_i : cnt_q - ONE;
          MODE_UPDN: begin
            if (!dir_q) begin
              if (cnt_q >= prd_i) begin
                dir_d = 1'b1;
                cnt_d = cnt_q - ONE;
              end else begin
                cnt_d = cnt_q + ONE;
              end
            end else if (cnt_q == '0) begin
              dir_d = 1'b0;
              cnt_d = ONE;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
          default: cnt_d = cnt_q;
        endcase
      end
    end
    wrap_o = adv && (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      zero_q <= 1'b0;
      prd_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      zero_q <= wrap_o;
      prd_q  <= adv && (cnt_d == prd_i);
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = zero_q;
  assign prd_o  = prd_q;

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_HOLD) |=> ($stable(cnt_q) && !zero_q && !prd_q));
  // R10
  zero_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q |-> (cnt_q == '0));
  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && mode_i == MODE_UP && cnt_q < prd_i) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CW  = 16,
  parameter int A_W = 3,
  parameter int B_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] count_o,
  output logic          zero_evt_o,
  output logic          prd_evt_o
);
  cnt_mode_e      mode_q, mode_d;
  logic           imm_q, imm_d;
  logic [A_W-1:0] k_q, k_d;
  logic [B_W-1:0] h_q, h_d;
  logic           ctrl_wr, prd_wr, tick, wrap;
  logic [CW-1:0]  prd_act;

  always_comb begin
    ctrl_wr = wr_en && !wr_sel;
    prd_wr  = wr_en && wr_sel;
    mode_d  = mode_q;
    imm_d   = imm_q;
    k_d     = k_q;
    h_d     = h_q;
    if (ctrl_wr) begin
      mode_d = cnt_mode_e'(wr_data[MODE_LSB +: 2]);
      imm_d  = wr_data[IMM_BIT];
      k_d    = wr_data[KDIV_LSB +: A_W];
      h_d    = wr_data[HDIV_LSB +: B_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_HOLD;
      imm_q  <= 1'b0;
      k_q    <= '0;
      h_q    <= '0;
    end else begin
      mode_q <= mode_d;
      imm_q  <= imm_d;
      k_q    <= k_d;
      h_q    <= h_d;
    end
  end

  pwm_tb_prescale #(.A_W(A_W), .B_W(B_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(ctrl_wr), .k_i(k_q), .h_i(h_q), .tick_o(tick)
  );

  pwm_tb_period #(.CW(CW)) u_prd (
    .clk(clk), .rst_n(rst_n), .wr_i(prd_wr), .imm_i(imm_q), .data_i(wr_data),
    .load_i(wrap), .active_o(prd_act)
  );

  pwm_tb_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode_q), .prd_i(prd_act),
    .cnt_o(count_o), .zero_o(zero_evt_o), .prd_o(prd_evt_o), .wrap_o(wrap)
  );
endmodule

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic        zero_evt_o, prd_evt_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt, m_dir, m_mode, m_imm, m_k, m_h, m_act, m_sh, m_pre;
  bit m_zero, m_prd;

  always #5 clk = ~clk;

  pwm_timebase dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_o(count_o), .zero_evt_o(zero_evt_o), .prd_evt_o(prd_evt_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_dir = 0; m_mode = 3; m_imm = 0; m_k = 0; m_h = 0;
      m_act = 0; m_sh = 0; m_pre = 0; m_zero = 0; m_prd = 0;
    end else begin
      int div, nxt, ndir;
      bit tk, adv;
      div  = (1 << m_k) * ((m_h == 0) ? 1 : 2 * m_h);
      tk   = (m_pre == div - 1);
      adv  = tk && (m_mode != 3);
      nxt  = m_cnt;
      ndir = m_dir;
      if (adv) begin
        if (m_act == 0) nxt = 0;
        else if (m_mode == 0) nxt = (m_cnt >= m_act) ? 0 : m_cnt + 1;
        else if (m_mode == 1) nxt = (m_cnt == 0) ? m_act : m_cnt - 1;
        else begin
          if (m_dir == 0) begin
            if (m_cnt >= m_act) begin ndir = 1; nxt = m_cnt - 1; end
            else nxt = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin ndir = 0; nxt = 1; end
            else nxt = m_cnt - 1;
          end
        end
      end
      m_zero = adv && (nxt == 0);
      m_prd  = adv && (nxt == m_act);
      if (adv && nxt == 0) m_act = m_sh;
      m_pre = tk ? 0 : m_pre + 1;
      if (wr_en && wr_sel) begin
        if (m_imm != 0) m_act = wr_data;
        m_sh = wr_data;
      end
      if (wr_en && !wr_sel) begin
        m_mode = wr_data[1:0];
        m_imm  = wr_data[3];
        m_k    = wr_data[12:10];
        m_h    = wr_data[9:7];
        m_pre  = 0;
      end
      m_cnt = nxt;
      m_dir = ndir;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (count_o !== m_cnt[15:0] || zero_evt_o !== m_zero || prd_evt_o !== m_prd) begin
      errors++;
      $display("FAIL %s: count/zero/prd actual %0d/%0b/%0b expected %0d/%0b/%0b",
               cur_req, count_o, zero_evt_o, prd_evt_o, m_cnt, m_zero, m_prd);
    end
  end

  task automatic wr(input bit sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ctrl(input int mode, input int imm, input int k, input int h);
    return (k << 10) | (h << 7) | (imm << 3) | mode;
  endfunction

  initial begin
    #1;
    cur_req = "R1";
    checks++;
    if (count_o !== 16'd0 || zero_evt_o !== 1'b0 || prd_evt_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs actual %0d/%0b/%0b expected 0/0/0",
               count_o, zero_evt_o, prd_evt_o);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R6"; run(8);
    cur_req = "R8"; wr(1, 5); run(10);          // hold mode: shadow not moved
    cur_req = "R11"; wr(0, ctrl(0, 1, 0, 0));   // up, immediate, period still 0 -> R11
    run(6);
    cur_req = "R9"; wr(1, 4); run(12);
    cur_req = "R3"; run(10);
    wr(1, 2); run(8);                          // shrink below count
    wr(1, 6); run(16);
    cur_req = "R4"; wr(0, ctrl(1, 1, 0, 0)); run(20);
    cur_req = "R5"; wr(1, 3); wr(0, ctrl(2, 1, 0, 0)); run(24);
    wr(1, 1); run(8);
    wr(1, 5); run(24);
    cur_req = "R6"; wr(0, ctrl(3, 1, 0, 0)); run(12);
    cur_req = "R7"; wr(0, ctrl(0, 1, 1, 0)); run(30);
    wr(0, ctrl(0, 1, 0, 3)); run(60);
    wr(0, ctrl(2, 1, 2, 1)); run(90);
    wr(0, ctrl(1, 1, 3, 2)); wr(0, ctrl(1, 1, 3, 2)); run(70);
    wr(1, 1); wr(0, ctrl(0, 1, 7, 7)); run(4000);
    cur_req = "R8"; wr(1, 4); wr(0, ctrl(0, 0, 0, 0)); run(15);
    wr(1, 9); run(30);
    wr(1, 2); run(20);
    cur_req = "R2"; wr(0, ctrl(1, 0, 0, 0)); run(20);
    cur_req = "R10"; wr(1, 0); run(12);
    wr(1, 3); run(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule